// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Tagged-Line Selective Invalidate

This block is a small direct-mapped first-level data cache, one word per line, that sits between a processor load/store port and a simple next-level memory port. Each request carries a memory-type attribute, taken from the page attribute of the address, that marks the word as shared message-buffer memory or as ordinary private memory. When a line is filled, the attribute is stored in that line as a tag bit.

The two memory types follow different policies. Private lines are write-back with write-allocate. Tagged lines are write-through, and a tagged write miss does not allocate a line. Tagged traffic is flagged on the memory port so that the next cache level passes it straight through. A single-cycle tagged invalidate command drops every tagged line and writes nothing back, while private lines stay resident. Because tagged lines are never dirty, nothing is lost when they are dropped. A separate full invalidate drops every line. Dirty private data is discarded by a full invalidate, and no command exists to write lines back.

Top module: `tagged_l1_cache`

## Requirements
- R1: After reset every line is invalid, `req_ready` is 1, `resp_valid` is 0 and `mem_req` is 0. The first access to any address therefore misses.
- R2: A read hit is accepted while idle and answered in the next cycle (`resp_valid` high for one cycle, `resp_rdata` = the stored word), with no memory request.
- R3: A read miss issues one memory read (`mem_we`=0) of the requested word address. After `mem_ack` the line holds `mem_rdata`, its tag bit equals the request's `req_mbt`, and the response carries that data.
- R4: A write hit to a private line (stored tag bit 0) updates the word, marks the line dirty and responds in the next cycle with no memory request. A private write miss fills the line first and then merges the write data into it.
- R5: When a miss must allocate into a line that is valid and dirty, the old word is first written to memory at the old line's address, and the fill follows.
- R6: A write to a tagged line, or a tagged write miss, is written through to memory with the write data. A hit also updates the line. A tagged write miss allocates no line. A tagged line is never dirty.
- R7: `mem_bypass` is 1 on fills and write-throughs made for tagged requests. It is 0 for private traffic and for all write-backs.
- R8: The tagged invalidate (`inv_tagged`) takes effect in one cycle. It clears the valid bit of every tagged line and makes no memory request. Private lines, dirty ones included, stay valid with their contents unchanged.
- R9: The full invalidate (`inv_all`) clears every line in one cycle without any write-back. Data held only in dirty lines is discarded.
- R10: The invalidate commands are taken only while idle. During any cycle in which either command is high, `req_ready` is 0.
- R11: A memory request holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stable until the cycle in which `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data |
| req_mbt | input | 1 | Memory-type attribute: 1 = message-buffer (tagged) memory |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | DATA_W | Load data, valid with resp_valid for loads |
| inv_tagged | input | 1 | Drop all tagged lines |
| inv_all | input | 1 | Drop all lines |
| mem_req | output | 1 | Memory request pending |
| mem_we | output | 1 | Memory write when 1, read when 0 |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_bypass | output | 1 | Next level should not cache this access |
| mem_ack | input | 1 | Memory completes the pending request |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ack |

## Verification
Directed sequences mix tagged and private addresses that share an index. This makes it possible to tell a write-back eviction from a clean replacement, and a write-through from a dirty private update. A tagged invalidate followed by reads of a retained private line and a dropped tagged line separates "selective" from "full" clearing. A full invalidate issued over a dirty line shows that the data is discarded and not written back. A long pseudo-random mix of loads, stores and both invalidates over 128 addresses then runs against a behavioural model. The model predicts every memory transaction (direction, address, data, bypass flag) and every load value, so an extra, missing or misrouted transfer is caught in the cycle it occurs.

// File: rtl/tcache_pkg.sv
package tcache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EVICT = 2'd1,
    ST_FILL  = 2'd2,
    ST_THRU  = 2'd3
  } cstate_e;
endpackage

// File: rtl/tcache_tags.sv
module tcache_tags #(
  parameter int LINES = 8,
  parameter int TAG_W = 9,
  localparam int INDEX_W = $clog2(LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INDEX_W-1:0] rd_idx,
  output logic               rd_valid,
  output logic               rd_mbt,
  output logic               rd_dirty,
  output logic [TAG_W-1:0]   rd_tag,
  input  logic               wr_en,
  input  logic [INDEX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0]   wr_tag,
  input  logic               wr_mbt,
  input  logic               wr_dirty,
  input  logic               clr_tagged,
  input  logic               clr_all,
  output logic [LINES-1:0]   valid_vec,
  output logic [LINES-1:0]   mbt_vec,
  output logic [LINES-1:0]   dirty_vec
);
  logic [TAG_W-1:0] tag_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    wire line_wr  = wr_en && (wr_idx == INDEX_W'(g));
    wire line_clr = clr_all || (clr_tagged && mbt_vec[g]);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_vec[g] <= 1'b0;
        mbt_vec[g]   <= 1'b0;
        dirty_vec[g] <= 1'b0;
        tag_q[g]     <= '0;
      end else if (line_clr) begin
        valid_vec[g] <= 1'b0;
        dirty_vec[g] <= 1'b0;
      end else if (line_wr) begin
        valid_vec[g] <= 1'b1;
        mbt_vec[g]   <= wr_mbt;
        dirty_vec[g] <= wr_dirty;
        tag_q[g]     <= wr_tag;
      end
    end
  end

  assign rd_valid = valid_vec[rd_idx];
  assign rd_mbt   = mbt_vec[rd_idx];
  assign rd_dirty = dirty_vec[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
endmodule

// File: rtl/tcache_data.sv
module tcache_data #(
  parameter int LINES  = 8,
  parameter int DATA_W = 32,
  localparam int INDEX_W = $clog2(LINES)
) (
  input  logic               clk,
  input  logic [INDEX_W-1:0] rd_idx,
  output logic [DATA_W-1:0]  rd_data,
  input  logic               wr_en,
  input  logic [INDEX_W-1:0] wr_idx,
  input  logic [DATA_W-1:0]  wr_data
);
  logic [DATA_W-1:0] word_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == INDEX_W'(g))) word_q[g] <= wr_data;
    end
  end

  assign rd_data = word_q[rd_idx];
endmodule

// File: rtl/tagged_l1_cache.sv
module tagged_l1_cache
  import tcache_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int LINES  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_mbt,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_rdata,
  input  logic              inv_tagged,
  input  logic              inv_all,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_bypass,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int INDEX_W = $clog2(LINES);
  localparam int TAG_W   = ADDR_W - INDEX_W;

  function automatic logic [INDEX_W-1:0] index_of(input logic [ADDR_W-1:0] a);
    return a[INDEX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:INDEX_W];
  endfunction

  cstate_e           state_q;
  logic [ADDR_W-1:0] cur_addr_q;
  logic [DATA_W-1:0] cur_wdata_q;
  logic              cur_write_q;
  logic              cur_mbt_q;
  logic [TAG_W-1:0]  victim_tag_q;

  logic               rd_valid, rd_mbt, rd_dirty;
  logic [TAG_W-1:0]   rd_tag;
  logic [DATA_W-1:0]  rd_data;
  logic [LINES-1:0]   valid_vec, mbt_vec, dirty_vec;

  // named internal events
  wire idle            = (state_q == ST_IDLE);
  wire [ADDR_W-1:0] look_addr = idle ? req_addr : cur_addr_q;
  wire [INDEX_W-1:0] look_idx = index_of(look_addr);
  wire hit             = rd_valid && (rd_tag == tag_of(look_addr));
  wire inv_all_fire    = idle && inv_all;
  wire inv_tagged_fire = idle && inv_tagged && !inv_all;
  assign req_ready     = idle && !inv_all && !inv_tagged;
  wire accept          = req_valid && req_ready;
  wire acc_wr_priv_hit = accept && hit && req_write && !rd_mbt;
  wire acc_wr_tag_hit  = accept && hit && req_write && rd_mbt;
  wire fill_done       = (state_q == ST_FILL) && mem_ack;
  wire line_write      = acc_wr_priv_hit || acc_wr_tag_hit || fill_done;
  wire line_mbt        = fill_done ? cur_mbt_q : rd_mbt;
  wire line_dirty      = fill_done ? (cur_write_q && !cur_mbt_q) : !rd_mbt;
  wire [DATA_W-1:0] line_data = fill_done ? (cur_write_q ? cur_wdata_q : mem_rdata)
                                          : req_wdata;

  tcache_tags #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_idx     (look_idx),
    .rd_valid   (rd_valid),
    .rd_mbt     (rd_mbt),
    .rd_dirty   (rd_dirty),
    .rd_tag     (rd_tag),
    .wr_en      (line_write),
    .wr_idx     (look_idx),
    .wr_tag     (tag_of(look_addr)),
    .wr_mbt     (line_mbt),
    .wr_dirty   (line_dirty),
    .clr_tagged (inv_tagged_fire),
    .clr_all    (inv_all_fire),
    .valid_vec  (valid_vec),
    .mbt_vec    (mbt_vec),
    .dirty_vec  (dirty_vec)
  );

  tcache_data #(.LINES(LINES), .DATA_W(DATA_W)) u_data (
    .clk     (clk),
    .rd_idx  (look_idx),
    .rd_data (rd_data),
    .wr_en   (line_write),
    .wr_idx  (look_idx),
    .wr_data (line_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      cur_addr_q   <= '0;
      cur_wdata_q  <= '0;
      cur_write_q  <= 1'b0;
      cur_mbt_q    <= 1'b0;
      victim_tag_q <= '0;
      resp_valid   <= 1'b0;
      resp_rdata   <= '0;
    end else begin
      resp_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          cur_addr_q  <= req_addr;
          cur_wdata_q <= req_wdata;
          cur_write_q <= req_write;
          cur_mbt_q   <= hit ? rd_mbt : req_mbt;
          if (hit) begin
            if (!req_write) begin
              resp_valid <= 1'b1;
              resp_rdata <= rd_data;
            end else if (rd_mbt) begin
              state_q <= ST_THRU;
            end else begin
              resp_valid <= 1'b1;
            end
          end else if (req_write && req_mbt) begin
            state_q <= ST_THRU;
          end else if (rd_valid && rd_dirty) begin
            victim_tag_q <= rd_tag;
            state_q      <= ST_EVICT;
          end else begin
            state_q <= ST_FILL;
          end
        end
        ST_EVICT: if (mem_ack) state_q <= ST_FILL;
        ST_FILL: if (mem_ack) begin
          resp_valid <= 1'b1;
          resp_rdata <= mem_rdata;
          state_q    <= ST_IDLE;
        end
        ST_THRU: if (mem_ack) begin
          resp_valid <= 1'b1;
          state_q    <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  wire evicting = (state_q == ST_EVICT);
  assign mem_req    = !idle;
  assign mem_we     = evicting || (state_q == ST_THRU);
  assign mem_addr   = evicting ? {victim_tag_q, look_idx} : cur_addr_q;
  assign mem_wdata  = evicting ? rd_data : cur_wdata_q;
  assign mem_bypass = !idle && !evicting && cur_mbt_q;
endmodule

// File: rtl/tcache_checker.sv
module tcache_checker #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int LINES  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              inv_tagged_fire,
  input logic              inv_all_fire,
  input logic [LINES-1:0]  valid_vec,
  input logic [LINES-1:0]  mbt_vec,
  input logic [LINES-1:0]  dirty_vec,
  input logic              accept,
  input logic              hit,
  input logic              req_write,
  input logic              resp_valid,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata
);
  assert_tagged_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    inv_tagged_fire |=> ((valid_vec & mbt_vec) == '0));

  assert_private_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    inv_tagged_fire |=> ((valid_vec & ~mbt_vec) == $past(valid_vec & ~mbt_vec)));

  assert_all_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all_fire |=> (valid_vec == '0));

  assert_inv_no_writeback_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_all_fire || inv_tagged_fire) |=> !mem_req);

  assert_tagged_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((valid_vec & mbt_vec & dirty_vec) == '0));

  assert_mem_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                               && $stable(mem_wdata)));

  assert_read_hit_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit && !req_write) |=> (resp_valid && !mem_req));
endmodule

bind tagged_l1_cache tcache_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)
) u_tcache_checker (
  .clk             (clk),
  .rst_n           (rst_n),
  .inv_tagged_fire (inv_tagged_fire),
  .inv_all_fire    (inv_all_fire),
  .valid_vec       (valid_vec),
  .mbt_vec         (mbt_vec),
  .dirty_vec       (dirty_vec),
  .accept          (accept),
  .hit             (hit),
  .req_write       (req_write),
  .resp_valid      (resp_valid),
  .mem_req         (mem_req),
  .mem_we          (mem_we),
  .mem_ack         (mem_ack),
  .mem_addr        (mem_addr),
  .mem_wdata       (mem_wdata)
);

// File: tb/test_tagged_l1_cache.sv
module test_tagged_l1_cache;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int NL = 8;
  localparam int MEMW = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          req_valid = 0, req_write = 0, req_mbt = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          inv_tagged = 0, inv_all = 0;
  logic          mem_ack = 0;
  logic [DW-1:0] mem_rdata = '0;
  wire           req_ready, resp_valid, mem_req, mem_we, mem_bypass;
  wire [DW-1:0]  resp_rdata, mem_wdata;
  wire [AW-1:0]  mem_addr;

  tagged_l1_cache #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL)) i_tagged_l1_cache (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mbt(req_mbt),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .inv_tagged(inv_tagged), .inv_all(inv_all),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_bypass(mem_bypass),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int vectors = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // behavioural memory and reference model
  logic [DW-1:0] ram [MEMW];
  logic [DW-1:0] ref_mem [MEMW];
  bit            m_v [NL];
  bit            m_t [NL];
  bit            m_d [NL];
  int            m_tag [NL];
  logic [DW-1:0] m_dat [NL];

  typedef struct { bit we; bit byp; int addr; logic [DW-1:0] data; } mop_t;
  mop_t expq [$];

  function automatic logic [DW-1:0] seed_word(input int a);
    return (32'(a) * 32'h0101_0101) ^ 32'hA500_0000;
  endfunction

  // memory responder: acknowledges two cycles after a request shows up
  int lat = 0;
  logic [AW-1:0] first_addr;
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      lat = 0;
    end else if (mem_req) begin
      if (lat == 0) first_addr = mem_addr;
      if (lat == 2) begin
        mop_t e;
        chk(mem_addr == first_addr, "R11", "address held until ack",
            DW'(mem_addr), DW'(first_addr));
        if (expq.size() == 0) begin
          chk(1'b0, "R8", "unexpected memory transfer", DW'(mem_addr), 32'hFFFF_FFFF);
        end else begin
          e = expq.pop_front();
          chk(mem_we == e.we && int'(mem_addr) == e.addr, "R5",
              "memory op kind/address", {19'd0, mem_we, mem_addr}, {19'd0, e.we, AW'(e.addr)});
          chk(mem_bypass == e.byp, "R7", "bypass flag", DW'(mem_bypass), DW'(e.byp));
          if (e.we) chk(mem_wdata == e.data, "R6", "memory write data", mem_wdata, e.data);
        end
        if (mem_we) ram[mem_addr] = mem_wdata;
        mem_rdata = ram[mem_addr];
        mem_ack = 1'b1;
      end
      lat++;
    end
  end

  task automatic model_req(input bit wr, input int a, input logic [DW-1:0] wd,
                           input bit mbt, output logic [DW-1:0] exp_rd, output bit fast);
    int idx = a % NL;
    int tg  = a / NL;
    bit h   = m_v[idx] && m_tag[idx] == tg;
    exp_rd = '0;
    fast = h && !(wr && m_t[idx]);
    if (h) begin
      if (!wr) exp_rd = m_dat[idx];
      else begin
        m_dat[idx] = wd;
        if (m_t[idx]) begin
          expq.push_back('{1, 1, a, wd});
          ref_mem[a] = wd;
        end else m_d[idx] = 1;
      end
    end else if (wr && mbt) begin
      expq.push_back('{1, 1, a, wd});
      ref_mem[a] = wd;
    end else begin
      if (m_v[idx] && m_d[idx]) begin
        expq.push_back('{1, 0, m_tag[idx] * NL + idx, m_dat[idx]});
        ref_mem[m_tag[idx] * NL + idx] = m_dat[idx];
      end
      expq.push_back('{0, mbt, a, '0});
      exp_rd = ref_mem[a];
      m_v[idx] = 1; m_tag[idx] = tg; m_t[idx] = mbt;
      m_dat[idx] = wr ? wd : ref_mem[a];
      m_d[idx] = wr;
    end
  endtask

  task automatic do_req(input bit wr, input int a, input logic [DW-1:0] wd,
                        input bit mbt, input string tag);
    logic [DW-1:0] exp_rd;
    bit fast;
    int cyc;
    model_req(wr, a, wd, mbt, exp_rd, fast);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = AW'(a); req_wdata = wd; req_mbt = mbt;
    #1 chk(req_ready == 1'b1, tag, "ready while idle", DW'(req_ready), 32'd1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    cyc = 1;
    while (!resp_valid && cyc < 60) begin
      @(negedge clk);
      cyc++;
    end
    chk(resp_valid == 1'b1, tag, "response arrives", DW'(resp_valid), 32'd1);
    if (fast) chk(cyc == 1, tag, "one-cycle hit latency", DW'(cyc), 32'd1);
    else      chk(cyc > 1, tag, "miss/through uses memory", DW'(cyc), 32'd2);
    if (!wr) chk(resp_rdata == exp_rd, tag, "load data", resp_rdata, exp_rd);
    chk(expq.size() == 0, tag, "all predicted memory ops done", DW'(expq.size()), 32'd0);
  endtask

  task automatic do_inv(input bit all, input string tag);
    @(negedge clk);
    if (all) inv_all = 1; else inv_tagged = 1;
    req_valid = 1; req_write = 0; req_addr = '0; req_mbt = 0;
    #1 chk(req_ready == 1'b0, "R10", "ready low during invalidate", DW'(req_ready), 32'd0);
    @(posedge clk);
    @(negedge clk);
    inv_all = 0; inv_tagged = 0; req_valid = 0;
    chk(mem_req == 1'b0, tag, "no write-back on invalidate", DW'(mem_req), 32'd0);
    for (int i = 0; i < NL; i++) if (all || m_t[i]) begin m_v[i] = 0; m_d[i] = 0; end
  endtask

  bit finished = 0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      vectors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    for (int i = 0; i < MEMW; i++) begin ram[i] = seed_word(i); ref_mem[i] = seed_word(i); end
    for (int i = 0; i < NL; i++) begin m_v[i] = 0; m_t[i] = 0; m_d[i] = 0; m_tag[i] = 0; m_dat[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", DW'(req_ready), 32'd1);
    chk(resp_valid == 1'b0, "R1", "no response after reset", DW'(resp_valid), 32'd0);
    chk(mem_req == 1'b0, "R1", "no memory request after reset", DW'(mem_req), 32'd0);

    do_req(0, 12'h005, '0, 0, "R1");            // cold miss
    do_req(0, 12'h005, '0, 0, "R2");            // read hit
    do_req(1, 12'h005, 32'h1111_2222, 0, "R4"); // private write hit, dirty
    do_req(0, 12'h005, '0, 0, "R4");
    do_req(0, 12'h805, '0, 1, "R5");            // dirty victim evicted, tagged fill
    do_req(1, 12'h805, 32'h3333_4444, 1, "R6"); // tagged write-through hit
    do_req(0, 12'h805, '0, 1, "R6");
    do_req(1, 12'h812, 32'h5555_6666, 1, "R6"); // tagged write miss, no allocate
    do_req(0, 12'h812, '0, 1, "R3");            // must miss and fetch written value
    do_req(1, 12'h003, 32'h7777_8888, 0, "R4"); // private write miss allocate
    do_req(0, 12'h003, '0, 0, "R4");
    do_inv(0, "R8");
    do_req(0, 12'h003, '0, 0, "R8");            // private dirty line retained
    do_req(0, 12'h805, '0, 1, "R8");            // tagged line refetched
    do_req(0, 12'h812, '0, 1, "R8");
    do_inv(1, "R9");
    do_req(0, 12'h003, '0, 0, "R9");            // dirty data discarded
    do_req(0, 12'h805, '0, 1, "R9");

    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[3:0] == 4'd0) do_inv(0, "R8");
      else if (lfsr[3:0] == 4'd1 && lfsr[4]) do_inv(1, "R9");
      else begin
        bit tg = lfsr[5];
        int a = (tg ? 2048 : 0) + int'(lfsr[11:6]);
        do_req(lfsr[7] && lfsr[2], a, {lfsr, lfsr ^ 16'h5A5A}, tg, "R3");
      end
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule